// File: doc/BRIEF.md
# EDO DRAM Access Cycle Sequencer

This block sits between a synchronous host and a 16-bit EDO DRAM whose address pins carry the row and the column one after the other. It takes single-word read or write requests and turns each one into a strobe sequence. First the row address is placed on the bus and the row strobe falls. Then the column address follows, and the byte-lane column strobes are pulsed. A write uses early-write timing, so the write strobe and the data are set up before any column strobe falls. A read lowers the output enable and samples the data bus once every access minimum has elapsed. The DRAM data bus is split into a driven value, an enable and a returned value, so that the tristate buffer can sit at the chip edge.

Every timing minimum is a parameter in nanoseconds. Each is turned into clock cycles with ceil(t / CLK_NS), and never fewer than one. After an access the row stays open. A later request to the same row is served with column strobes alone. A request to another row closes the row, waits out precharge and reopens. The open row is also closed before the maximum row-strobe low time runs out.

An external refresh engine gets the DRAM bus only between accesses, with the row strobe high and precharge complete.

Top module: `edo_seq`

## Requirements
- R1: While reset is asserted (active-low) and after it is released: ras_n high, cas_n = 2'b11, we_n high, oe_n high, dq_oe low, rvalid low, ref_gnt low. ready is high when ref_req is low.
- R2: The row address addr[19:10] is on dram_a when ras_n falls and for at least ceil(tRAH) cycles after. The column address addr[9:0] follows and stays until the access ends. A column strobe is low only while ras_n is low, and it falls at least ceil(tRCD) cycles after ras_n.
- R3: Every ras_n low period lasts at least ceil(tRAS) cycles. Every high period between two accesses lasts at least ceil(tRP) cycles.
- R4: Each column strobe stays low for at least ceil(tCAS) cycles and high for at least ceil(tCP) cycles. Successive falling edges are at least ceil(tPC) cycles apart.
- R5: be[0] selects cas_n[0], which qualifies data bits 7:0. be[1] selects cas_n[1], which qualifies bits 15:8. Only selected strobes fall. A write changes only the enabled bytes, and a read returns zero in the bytes that are not enabled.
- R6: For a write, we_n is low and dq_oe is high before the first column strobe falls. oe_n stays high. The data is held for at least ceil(tDH) cycles of strobe low.
- R7: For a read, we_n stays high and oe_n falls with the column strobe. rdata is captured no earlier than ceil(tRAC) cycles after ras_n fell, ceil(tCAC) cycles after the strobe fell, ceil(tAA) cycles after the column was applied and ceil(tOE) cycles after oe_n fell. rvalid pulses for one cycle with rdata.
- R8: dq_oe is never high while oe_n is low. It does not rise until ceil(tOFF) cycles after the strobes of a read have risen.
- R9: A request to the row that is open is served without a new ras_n falling edge.
- R10: A request to a different row closes the open row, precharges, reopens with the new row and is then served correctly.
- R11: ras_n is never held low for ceil(tRASP) cycles or more. An idle open row is closed by the block itself.
- R12: ref_gnt rises only after ras_n has been high for ceil(tRP) cycles. While ref_gnt is high, all strobes are inactive, dq_oe is low and ready is low. A refresh request wins over a host request that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken on a cycle where ready is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Row in bits 19:10, column in bits 9:0 |
| be | input | 2 | Byte enables, bit 0 for data 7:0, bit 1 for data 15:8 |
| wdata | input | 16 | Write data |
| ready | output | 1 | A request can be taken this cycle |
| rvalid | output | 1 | One-cycle pulse with read data |
| rdata | output | 16 | Read data, disabled bytes zero |
| ref_req | input | 1 | External refresh engine asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh engine |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data bus driver |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
A refresh request and a host request can arrive in the same cycle, either while the row is open or while the block is idle. The bench holds a read open on a page, then raises ref_req and req together. It then judges three things. ready must drop at once. The grant must come only after the row has closed and precharge has run its full count, with every strobe quiet for as long as it is held. The held read must finish with the right data once the refresh request is withdrawn. A strobe-level model of the DRAM counts pulse widths and edge spacing on every cycle, so the same run also judges the timing rules.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int CLK_NS    = 10,
  parameter int T_RAH_NS  = 10,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAS_NS  = 60,
  parameter int T_RP_NS   = 40,
  parameter int T_CAS_NS  = 10,
  parameter int T_CP_NS   = 10,
  parameter int T_PC_NS   = 40,
  parameter int T_RASP_NS = 100000,
  parameter int T_DH_NS   = 15,
  parameter int T_RAC_NS  = 60,
  parameter int T_CAC_NS  = 15,
  parameter int T_AA_NS   = 30,
  parameter int T_OE_NS   = 15,
  parameter int T_OFF_NS  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [19:0] addr,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic        ready,
  output logic        rvalid,
  output logic [15:0] rdata,
  input  logic        ref_req,
  output logic        ref_gnt,
  output logic [9:0]  dram_a,
  output logic        dram_ras_n,
  output logic [1:0]  dram_cas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [15:0] dram_dq_out,
  output logic        dram_dq_oe,
  input  logic [15:0] dram_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_RAH  = cyc(T_RAH_NS);
  localparam int N_RCD  = cyc(T_RCD_NS);
  localparam int N_RAS  = cyc(T_RAS_NS);
  localparam int N_RP   = cyc(T_RP_NS);
  localparam int N_CAS  = cyc(T_CAS_NS);
  localparam int N_CP   = cyc(T_CP_NS);
  localparam int N_PC   = cyc(T_PC_NS);
  localparam int N_RASP = cyc(T_RASP_NS);
  localparam int N_DH   = cyc(T_DH_NS);
  localparam int N_RAC  = cyc(T_RAC_NS);
  localparam int N_CAC  = cyc(T_CAC_NS);
  localparam int N_AA   = cyc(T_AA_NS);
  localparam int N_OE   = cyc(T_OE_NS);
  localparam int N_OFF  = cyc(T_OFF_NS);
  localparam int N_GUARD = N_PC + N_CP + N_OFF + N_CAS + N_DH + N_RAC + N_CAC + N_AA + N_OE + 4;
  localparam int N_LIM0  = N_RASP - N_GUARD;
  localparam int N_LIM   = (N_LIM0 > N_RAS) ? N_LIM0 : N_RAS;
  localparam int CW      = $clog2(N_RASP + 1) + 1;

  localparam logic [CW-1:0] M_RAH  = CW'(N_RAH - 1);
  localparam logic [CW-1:0] M_RCD  = CW'(N_RCD - 1);
  localparam logic [CW-1:0] M_RAS  = CW'(N_RAS - 1);
  localparam logic [CW-1:0] M_RP   = CW'(N_RP - 1);
  localparam logic [CW-1:0] M_CAS  = CW'(N_CAS - 1);
  localparam logic [CW-1:0] M_CP   = CW'(N_CP - 1);
  localparam logic [CW-1:0] M_PC   = CW'(N_PC - 1);
  localparam logic [CW-1:0] M_DH   = CW'(N_DH - 1);
  localparam logic [CW-1:0] M_RAC  = CW'(N_RAC - 1);
  localparam logic [CW-1:0] M_CAC  = CW'(N_CAC - 1);
  localparam logic [CW-1:0] M_AA   = CW'(N_AA - 1);
  localparam logic [CW-1:0] M_OE   = CW'(N_OE - 1);
  localparam logic [CW-1:0] M_OFF  = CW'(N_OFF - 1);
  localparam logic [CW-1:0] M_LIM  = CW'(N_LIM - 1);
  localparam logic [CW-1:0] K_RASP = CW'(N_RASP);

  typedef enum logic [2:0] {
    S_IDLE, S_ASR, S_RAH, S_COL, S_CASL, S_PAGE, S_PRE, S_REF
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, ras_cnt, col_cnt, pc_cnt, hi_cnt, off_cnt;
  logic [9:0]    row_q, col_q;
  logic          wr_q, pend;
  logic [1:0]    be_q;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  wire row_hit = (addr[19:10] == row_q);
  wire closing = ref_req || (ras_cnt >= M_LIM);
  assign ready   = (st == S_IDLE && !ref_req) || (st == S_PAGE && !pend && !closing);
  assign ref_gnt = (st == S_REF);
  wire take   = req && ready;
  wire wr_nx  = take ? we : wr_q;
  wire ras_ok = ras_cnt >= M_RAS;
  wire cas_go = (ras_cnt >= M_RCD) && (pc_cnt >= M_PC) && (hi_cnt >= M_CP)
                && (wr_q ? dram_dq_oe : 1'b1);
  wire rd_ok  = (cnt >= M_CAC) && (cnt >= M_OE) && (ras_cnt >= M_RAC) && (col_cnt >= M_AA);
  wire cas_ok = (cnt >= M_CAS) && (wr_q ? (cnt >= M_DH) : rd_ok);
  wire rd_end = (st == S_CASL) && (st_n == S_PAGE) && !wr_q;
  wire low_nx = (st_n == S_RAH) || (st_n == S_COL) || (st_n == S_CASL) || (st_n == S_PAGE);
  wire col_nx = (st_n == S_COL) || (st_n == S_CASL);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE: if (ref_req) st_n = S_REF;
              else if (req) st_n = S_ASR;
      S_ASR:  st_n = S_RAH;
      S_RAH:  if (cnt >= M_RAH) st_n = S_COL;
      S_COL:  if (cas_go) st_n = S_CASL;
      S_CASL: if (cas_ok) st_n = S_PAGE;
      S_PAGE: if (take && row_hit) st_n = S_COL;
              else if ((take || pend || closing) && ras_ok) st_n = S_PRE;
      S_PRE:  if (cnt >= M_RP) st_n = pend ? S_ASR : S_IDLE;
      S_REF:  if (!ref_req) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0; ras_cnt <= '0; col_cnt <= '0;
      pc_cnt <= '1; hi_cnt <= '1; off_cnt <= '1;
      row_q <= '0; col_q <= '0; wr_q <= 1'b0; be_q <= 2'b00; pend <= 1'b0;
      dram_a <= '0; dram_ras_n <= 1'b1; dram_cas_n <= 2'b11;
      dram_we_n <= 1'b1; dram_oe_n <= 1'b1;
      dram_dq_out <= '0; dram_dq_oe <= 1'b0;
      rvalid <= 1'b0; rdata <= '0;
    end else begin
      st      <= st_n;
      cnt     <= (st_n != st) ? '0 : inc(cnt);
      ras_cnt <= (st == S_ASR) ? '0 : inc(ras_cnt);
      col_cnt <= (st_n == S_COL && st != S_COL) ? '0 : inc(col_cnt);
      pc_cnt  <= (st_n == S_CASL && st != S_CASL) ? '0 : inc(pc_cnt);
      hi_cnt  <= (st == S_CASL) ? '0 : inc(hi_cnt);
      off_cnt <= (st == S_CASL && !wr_q) ? '0 : inc(off_cnt);
      if (take) begin
        row_q <= addr[19:10];
        col_q <= addr[9:0];
        wr_q  <= we;
        be_q  <= be;
        dram_dq_out <= wdata;
      end
      if (take && st == S_PAGE && !row_hit) pend <= 1'b1;
      else if (st == S_PRE && st_n == S_ASR) pend <= 1'b0;
      if (st_n == S_ASR)
        dram_a <= take ? addr[19:10] : row_q;
      else if (st_n == S_COL && st != S_COL)
        dram_a <= take ? addr[9:0] : col_q;
      dram_ras_n <= !low_nx;
      dram_cas_n <= (st_n == S_CASL) ? ~be_q : 2'b11;
      dram_we_n  <= !(wr_nx && col_nx);
      dram_oe_n  <= !(!wr_nx && st_n == S_CASL);
      dram_dq_oe <= wr_nx && col_nx && (dram_dq_oe || off_cnt >= M_OFF);
      rvalid     <= rd_end;
      if (rd_end) rdata <= dram_dq_in & {{8{be_q[1]}}, {8{be_q[0]}}};
    end
  end

  a_r2_cas_within_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != 2'b11) |-> !dram_ras_n);
  a_r3_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ($past(ras_cnt) >= M_RAS));
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != 2'b11 && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));
  a_r7_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);
  a_r11_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_cnt < K_RASP));
  a_r12_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n == 2'b11 && !dram_dq_oe && !ready));

endmodule

// File: tb/edo_seq_test.sv
module edo_seq_test;
  localparam int N_RAS = 3, N_RP = 2, N_PC = 2, N_RAC = 3, N_OFF = 3, N_RASP = 40;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, ref_req = 0;
  logic [19:0] addr = '0;
  logic [1:0] be = 2'b11;
  logic [15:0] wdata = '0;
  logic ready, rvalid, ref_gnt, ras_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, dq_out, dq_in;
  logic [1:0] cas_n;
  logic [9:0] a;

  always #10 clk = ~clk;

  edo_seq #(.CLK_NS(20), .T_OFF_NS(50), .T_RASP_NS(800)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_a(a), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  // strobe-level DRAM model
  logic [15:0] mem [0:255];
  logic [9:0] m_row = '0, m_col = '0;
  logic [1:0] pcas = 2'b11;
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  always @(negedge ras_n) m_row = a;
  always @(cas_n) begin
    if (pcas == 2'b11 && cas_n != 2'b11) m_col = a;
    if (pcas[0] && !cas_n[0] && !we_n) mem[{m_row[3:0], a[3:0]}][7:0] = dq_out[7:0];
    if (pcas[1] && !cas_n[1] && !we_n) mem[{m_row[3:0], a[3:0]}][15:8] = dq_out[15:8];
    pcas = cas_n;
  end
  assign dq_in = (!oe_n && we_n && cas_n != 2'b11) ? mem[{m_row[3:0], m_col[3:0]}] : 16'h0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // timing monitor
  int ras_lo = 0, ras_hi = 0, ras_falls = 0, max_lo = 0, cas_gap = 99, rd_gap = 99;
  int v2 = 0, v3 = 0, v4 = 0, v6 = 0, v7 = 0, v8 = 0, v12 = 0;
  bit had_low = 0, p_ras = 1, p_gnt = 0;
  logic [1:0] p_cas = 2'b11;
  always @(negedge clk) if (rst_n) begin
    if (!ras_n) begin
      if (p_ras) begin
        ras_falls++;
        if (had_low && ras_hi < N_RP) v3++;
        ras_lo = 0;
      end
      ras_lo++;
      if (ras_lo > max_lo) max_lo = ras_lo;
    end else begin
      if (!p_ras) begin
        if (ras_lo < N_RAS) v3++;
        ras_hi = 0;
        had_low = 1;
      end
      ras_hi++;
    end
    cas_gap++;
    if (p_cas == 2'b11 && cas_n != 2'b11) begin
      if (cas_gap < N_PC) v4++;
      cas_gap = 0;
      if (ras_n) v2++;
      if (we_n && oe_n) v7++;
      if (!we_n && (!dq_oe || !oe_n)) v6++;
    end
    if (!oe_n && cas_n != 2'b11) rd_gap = 0; else rd_gap++;
    if (dq_oe && (rd_gap <= N_OFF || !oe_n)) v8++;
    if (rvalid && ras_lo < N_RAC + 1) v7++;
    if (ref_gnt) begin
      if (!ras_n || cas_n != 2'b11 || dq_oe || ready || !we_n || !oe_n) v12++;
      if (!p_gnt && ras_hi < N_RP + 1) v12++;
    end
    p_ras = ras_n; p_cas = cas_n; p_gnt = ref_gnt;
  end

  task automatic issue(input logic w, input logic [19:0] ad, input logic [1:0] b, input logic [15:0] d,
                       output bit ok);
    ok = 0;
    req = 1; we = w; addr = ad; be = b; wdata = d;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ready) begin ok = 1; break; end
    end
    @(negedge clk);
    req = 0;
  endtask

  task automatic host_write(input logic [19:0] ad, input logic [1:0] b, input logic [15:0] d, input string rq);
    bit ok;
    issue(1'b1, ad, b, d, ok);
    check(ok, rq, 0, 1);
  endtask

  task automatic host_read(input logic [19:0] ad, input logic [1:0] b, input logic [15:0] exp, input string rq);
    bit ok, got;
    logic [15:0] v = 'x;
    got = 0;
    issue(1'b0, ad, b, 16'h0, ok);
    if (rvalid) begin got = 1; v = rdata; end
    for (int i = 0; i < 100 && !got; i++) begin
      @(negedge clk);
      if (rvalid) begin got = 1; v = rdata; end
    end
    check(ok && got && v == exp, rq, v, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ras_n && cas_n == 2'b11 && we_n && oe_n && !dq_oe && !rvalid && !ref_gnt,
          "R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n, dq_oe}, 6'b111110);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready && ras_n && cas_n == 2'b11 && !dq_oe && !ref_gnt, "R1 ready after reset",
          {ready, ras_n, cas_n}, 4'b1111);
  endtask

  task automatic t_random;
    int f0;
    host_write({10'd3, 10'd5}, 2'b11, 16'h1234, "R6 write taken");
    f0 = ras_falls;
    host_read({10'd5, 10'd5}, 2'b11, 16'h0000, "R10 other row reads blank");
    check(ras_falls == f0 + 1, "R10 miss reopens row", ras_falls - f0, 1);
    f0 = ras_falls;
    host_read({10'd3, 10'd5}, 2'b11, 16'h1234, "R7 R2 read back row/col");
    check(ras_falls == f0 + 1, "R10 second miss reopens", ras_falls - f0, 1);
  endtask

  task automatic t_page;
    int f0;
    host_read({10'd6, 10'd1}, 2'b11, 16'h0000, "R10 open row 6");
    f0 = ras_falls;
    host_write({10'd6, 10'd2}, 2'b11, 16'hBEEF, "R9 page write taken");
    host_read({10'd6, 10'd2}, 2'b11, 16'hBEEF, "R9 page read data");
    host_write({10'd6, 10'd3}, 2'b11, 16'h5A5A, "R8 write after read");
    check(ras_falls == f0, "R9 no new row strobe on hit", ras_falls - f0, 0);
    host_read({10'd6, 10'd3}, 2'b11, 16'h5A5A, "R8 turnaround data intact");
  endtask

  task automatic t_lanes;
    host_write({10'd3, 10'd5}, 2'b01, 16'hAAAA, "R5 low lane write");
    host_read({10'd3, 10'd5}, 2'b11, 16'h12AA, "R5 only low byte changed");
    host_read({10'd3, 10'd5}, 2'b10, 16'h1200, "R5 disabled byte zero");
    host_write({10'd3, 10'd5}, 2'b10, 16'h77FF, "R5 high lane write");
    host_read({10'd3, 10'd5}, 2'b11, 16'h77AA, "R5 only high byte changed");
  endtask

  task automatic t_limit;
    host_read({10'd6, 10'd2}, 2'b11, 16'hBEEF, "R11 open a page");
    repeat (60) @(negedge clk);
    check(ras_n == 1'b1, "R11 idle row closed", ras_n, 1);
    check(max_lo <= N_RASP - 1, "R11 longest row low", max_lo, N_RASP - 1);
  endtask

  task automatic t_refresh_clash;
    bit g = 0;
    host_read({10'd3, 10'd5}, 2'b11, 16'h77AA, "R12 open page before clash");
    ref_req = 1; req = 1; we = 0; addr = {10'd6, 10'd2}; be = 2'b11;
    #1;
    check(!ready, "R12 refresh blocks host at once", ready, 0);
    for (int i = 0; i < 50 && !g; i++) begin
      @(negedge clk);
      if (ref_gnt) g = 1;
    end
    check(g, "R12 grant given", g, 1);
    check(ras_n && ras_hi >= N_RP + 1, "R12 precharge done at grant", ras_hi, N_RP + 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ref_gnt && !ready && ras_n && cas_n == 2'b11 && !dq_oe, "R12 quiet during grant",
            {ref_gnt, ready, ras_n, cas_n, dq_oe}, 6'b101110);
    end
    ref_req = 0;
    host_read({10'd6, 10'd2}, 2'b11, 16'hBEEF, "R12 held read completes");
  endtask

  task automatic t_monitor;
    check(v2 == 0, "R2 column strobe inside row strobe", v2, 0);
    check(v3 == 0, "R3 row strobe widths", v3, 0);
    check(v4 == 0, "R4 column strobe spacing", v4, 0);
    check(v6 == 0, "R6 write setup at strobe", v6, 0);
    check(v7 == 0, "R7 read strobes and access time", v7, 0);
    check(v8 == 0, "R8 bus turnaround", v8, 0);
    check(v12 == 0, "R12 grant conditions", v12, 0);
  endtask

  initial begin
    t_reset;
    t_random;
    t_page;
    t_lanes;
    t_limit;
    t_refresh_clash;
    repeat (5) @(negedge clk);
    t_monitor;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1..R12 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule